// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the decision core of an eight-input interrupt controller. It catches rising edges on the request lines into a request register, drops the requests blocked by a mask register, and picks the best of the rest. Priority is counted from a movable base index and wraps around the eight inputs. The block then compares that choice against the levels already in service and raises an interrupt line only when the new request outranks all of them.

When the processor acknowledges, the winning request moves into the in-service register and its 3-bit number is latched on the vector output. Two modes change what the acknowledge does. With automatic end-of-interrupt, no in-service bit is kept. If rotation is also enabled, the priority base moves to the input just after the winner. A third mode, used only when the unit is a cascade master, leaves the cascade input out of the in-service comparison, so that a slave can nest its own interrupts. Decoding of the programming port and the cascade wiring belong to the surrounding logic.

Top module: `irq_prio_resolver`

## Requirements
- R1: A request bit is set only when its input is sampled high on a clock edge after being sampled low on the edge before. An input that is held high does not set the bit again once it has been acknowledged.
- R2: The candidate set is the request register with the mask register's set bits removed. The mask register loads `mask_i` on a clock edge when `mask_wr_i` is high. `none_o` is high exactly when the candidate set is empty.
- R3: Input k has offset (k - base) mod 8. The candidate with the lowest offset wins.
- R4: `int_o` is high only when the winning candidate's offset is strictly lower than the lowest in-service offset. An empty in-service set counts as offset 8.
- R5: When `sfnm_i` is high and the unit is a cascade master (parameter `IS_MASTER`), in-service bit 2 is ignored in the R4 comparison.
- R6: An edge with `ack_i` and `int_o` both high sets the winner's in-service bit and clears its request bit. From the next cycle, `vec_o` holds the winner's number.
- R7: An edge with `ack_i` high and `int_o` low changes neither the request register, the in-service register nor `vec_o`.
- R8: With `aeoi_i` high, an acknowledge leaves the in-service register unchanged.
- R9: With `aeoi_i` and `rot_aeoi_i` both high, an acknowledge sets the priority base to (winner + 1) mod 8.
- R10: While `rst_ni` is low, all registers are cleared: request, in-service, mask, previous level, base and vector. After reset, `int_o` = 0, `none_o` = 1 and `vec_o` = 0.
- R11: The priority base loads `base_i` on a clock edge when `base_wr_i` is high. A direct load takes precedence over R9 when both happen on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Request input lines |
| mask_wr_i | input | 1 | Load strobe for the mask register |
| mask_i | input | 8 | New mask value, 1 blocks the input |
| base_wr_i | input | 1 | Load strobe for the priority base |
| base_i | input | 3 | New priority base index |
| sfnm_i | input | 1 | Special fully nested mode |
| aeoi_i | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_aeoi_i | input | 1 | Rotate priority on automatic end-of-interrupt |
| ack_i | input | 1 | Acknowledge strobe, one cycle per acknowledge |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 3 | Number of the last acknowledged input |
| none_o | output | 1 | No unmasked request pending |

## Verification
The assertions check the following on every cycle:
- a request bit rises only after its input was high;
- `int_o` never rises without a candidate;
- an acknowledge that is taken latches the resolver's winner and sets its in-service bit;
- an acknowledge that is not taken leaves the state alone;
- automatic end-of-interrupt keeps the in-service register unchanged;
- rotation moves the base to one past the winner.

The resolved order itself can only be shown by the bench's scenarios: which input wins under a rotated base, how a held level is ignored after an acknowledge, how a lower in-service level blocks a new request, and the effect of the cascade-master exception. The random run compares every cycle against an independent model.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  typedef struct packed {
    logic sfnm;
    logic aeoi;
    logic rot_aeoi;
  } irq_mode_t;
endpackage

// File: rtl/irq_edge.sv
module irq_edge #(
  parameter int N_IRQ = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  output logic [N_IRQ-1:0] rise_o
);
  logic [N_IRQ-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else         last_q <= irq_i;
  end

  assign rise_o = irq_i & ~last_q;
endmodule

// File: rtl/prio_find.sv
module prio_find #(
  parameter int N_IRQ = 8,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] req_i,
  input  logic [IDX_W-1:0] base_i,
  output logic [IDX_W:0]   off_o,  // N_IRQ when empty
  output logic [IDX_W-1:0] num_o
);
  logic [N_IRQ-1:0] rot;

  // rotate so that bit 0 is the input at the base
  for (genvar k = 0; k < N_IRQ; k++) begin : g_rot
    logic [IDX_W-1:0] src;
    assign src    = IDX_W'(k) + base_i;
    assign rot[k] = req_i[src];
  end

  always_comb begin
    off_o = (IDX_W+1)'(N_IRQ);
    for (int k = N_IRQ-1; k >= 0; k--)
      if (rot[k]) off_o = (IDX_W+1)'(k);
  end

  assign num_o = off_o[IDX_W-1:0] + base_i;
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_res_pkg::*;
#(
  parameter int N_IRQ    = 8,
  parameter int CASC_IDX = 2,
  parameter bit IS_MASTER = 1'b1,
  localparam int IDX_W   = $clog2(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             mask_wr_i,
  input  logic [N_IRQ-1:0] mask_i,
  input  logic             base_wr_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic             sfnm_i,
  input  logic             aeoi_i,
  input  logic             rot_aeoi_i,
  input  logic             ack_i,
  output logic             int_o,
  output logic [IDX_W-1:0] vec_o,
  output logic             none_o
);
  irq_mode_t mode;
  assign mode = '{sfnm: sfnm_i, aeoi: aeoi_i, rot_aeoi: rot_aeoi_i};

  logic [N_IRQ-1:0] irr_q, isr_q, mask_q, rise, cand, isr_cmp, win_bit;
  logic [IDX_W-1:0] base_q, vec_q, win_num, isr_num;
  logic [IDX_W:0]   pend_off, isr_off;
  logic             take;

  irq_edge #(.N_IRQ(N_IRQ)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irq_i (irq_i),
    .rise_o(rise)
  );

  assign cand = irr_q & ~mask_q;

  if (IS_MASTER) begin : g_master
    logic [N_IRQ-1:0] casc_bit;
    assign casc_bit = N_IRQ'(1) << CASC_IDX;
    assign isr_cmp  = mode.sfnm ? (isr_q & ~casc_bit) : isr_q;
  end else begin : g_slave
    assign isr_cmp = isr_q;
  end

  prio_find #(.N_IRQ(N_IRQ)) u_pend (
    .req_i (cand),
    .base_i(base_q),
    .off_o (pend_off),
    .num_o (win_num)
  );

  prio_find #(.N_IRQ(N_IRQ)) u_serv (
    .req_i (isr_cmp),
    .base_i(base_q),
    .off_o (isr_off),
    .num_o (isr_num)
  );

  assign int_o   = pend_off < isr_off;
  assign none_o  = ~|cand;
  assign take    = ack_i & int_o;
  assign win_bit = N_IRQ'(1) << win_num;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      isr_q  <= '0;
      mask_q <= '0;
      base_q <= '0;
      vec_q  <= '0;
    end else begin
      irr_q <= (take ? (irr_q & ~win_bit) : irr_q) | rise;
      if (take) begin
        vec_q <= win_num;
        if (!mode.aeoi) isr_q <= isr_q | win_bit;
      end
      if (mask_wr_i) mask_q <= mask_i;
      if (base_wr_i)
        base_q <= base_i;
      else if (take && mode.aeoi && mode.rot_aeoi)
        base_q <= win_num + IDX_W'(1);
    end
  end

  assign vec_o = vec_q;

  // assertions
  for (genvar g = 0; g < N_IRQ; g++) begin : g_chk_edge
    p_set_needs_input_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irr_q[g]) |-> $past(irq_i[g]));
  end

  p_int_has_cand_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> !none_o);

  p_ack_vec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o) |=> vec_o == $past(win_num));

  p_ack_isr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o && !aeoi_i) |=> isr_q[$past(win_num)]);

  p_idle_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !int_o) |=> $stable(isr_q) && $stable(vec_o));

  p_aeoi_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o && aeoi_i) |=> $stable(isr_q));

  p_rotate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o && aeoi_i && rot_aeoi_i && !base_wr_i)
      |=> base_q == $past(win_num) + IDX_W'(1));

  logic unused_ok;
  assign unused_ok = ^isr_num;
endmodule

// File: tb/sim_irq_prio_resolver.sv
module sim_irq_prio_resolver;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] irq = '0, mask = '0;
  logic       mask_wr = 0, base_wr = 0, sfnm = 0, aeoi = 0, rot = 0, ack = 0;
  logic [2:0] base = '0;
  logic       int_o, none_o;
  logic [2:0] vec_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_irr, m_isr, m_mask, m_last;
  logic [2:0] m_base, m_vec;

  always #2 clk = ~clk;

  irq_prio_resolver u0 (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .mask_wr_i(mask_wr), .mask_i(mask),
    .base_wr_i(base_wr), .base_i(base), .sfnm_i(sfnm), .aeoi_i(aeoi),
    .rot_aeoi_i(rot), .ack_i(ack), .int_o(int_o), .vec_o(vec_o), .none_o(none_o)
  );

  function automatic int best(logic [7:0] v, logic [2:0] b);
    for (int k = 0; k < 8; k++)
      if (v[3'(b + 3'(k))]) return k;
    return 8;
  endfunction

  function automatic bit m_int();
    logic [7:0] s;
    s = sfnm ? (m_isr & 8'hFB) : m_isr;
    return best(m_irr & ~m_mask, m_base) < best(s, m_base);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [7:0] nirr, nisr;
    logic [2:0] nbase, w;
    nirr = m_irr; nisr = m_isr; nbase = m_base;
    w = 3'(best(m_irr & ~m_mask, m_base)) + m_base;
    if (ack && m_int()) begin
      nirr[w] = 1'b0;
      if (!aeoi) nisr[w] = 1'b1;
      else if (rot) nbase = w + 3'd1;
      m_vec = w;
    end
    nirr |= irq & ~m_last;
    if (base_wr) nbase = base;
    if (mask_wr) m_mask = mask;
    m_last = irq; m_irr = nirr; m_isr = nisr; m_base = nbase;
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk);
    chk("R4 int_o", int'(int_o), int'(m_int()));
    chk("R2 none_o", int'(none_o), int'((m_irr & ~m_mask) == 8'h0));
    chk("R6 vec_o", int'(vec_o), int'(m_vec));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; irq = '0; mask = '0; mask_wr = 0; base_wr = 0; base = '0;
    sfnm = 0; aeoi = 0; rot = 0; ack = 0;
    @(negedge clk);
    rst_ni = 1;
    m_irr = '0; m_isr = '0; m_mask = '0; m_last = '0; m_base = '0; m_vec = '0;
    chk("R10 int_o", int'(int_o), 0);
    chk("R10 none_o", int'(none_o), 1);
    chk("R10 vec_o", int'(vec_o), 0);
  endtask

  task automatic pulse_ack();
    ack = 1; cyc(); ack = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    do_reset();

    // R1: edge on input 5, held high
    irq = 8'h20; cyc();
    chk("R1 edge raises int", int'(int_o), 1);
    pulse_ack();
    chk("R6 vec after ack", int'(vec_o), 5);
    cyc();
    chk("R1 held level no retrigger", int'(none_o), 1);

    // R4: lower priority blocked by in-service 5, higher preempts
    irq = 8'h60; cyc();
    chk("R4 blocked by in-service", int'(int_o), 0);
    chk("R2 pending visible", int'(none_o), 0);
    irq = 8'h68; cyc();
    chk("R4 higher preempts", int'(int_o), 1);
    pulse_ack();
    chk("R6 vec preempt", int'(vec_o), 3);

    // R3 / R11: base 6, auto-EOI, order 7,1,4
    do_reset();
    base_wr = 1; base = 3'd6; aeoi = 1; cyc(); base_wr = 0;
    irq = 8'h92; cyc();
    ack = 1; cyc();
    chk("R11 R3 first winner", int'(vec_o), 7);
    chk("R8 no in-service kept", int'(int_o), 1);
    cyc();
    chk("R3 second winner", int'(vec_o), 1);
    cyc();
    chk("R3 third winner", int'(vec_o), 4);
    ack = 0;
    chk("R3 all served", int'(none_o), 1);

    // R9: rotation on auto-EOI
    do_reset();
    aeoi = 1; rot = 1;
    irq = 8'h24; cyc(); pulse_ack();
    chk("R9 first", int'(vec_o), 2);
    irq = 8'h26; cyc(); pulse_ack();
    chk("R9 rotated winner", int'(vec_o), 5);

    // R5: cascade input in service
    do_reset();
    irq = 8'h04; cyc(); pulse_ack();
    irq = 8'h00; cyc();
    irq = 8'h04; cyc();
    chk("R5 off blocks", int'(int_o), 0);
    sfnm = 1; #1;
    chk("R5 on allows", int'(int_o), 1);
    cyc(); sfnm = 0;

    // R7 / R2: ack with nothing eligible
    do_reset();
    mask_wr = 1; mask = 8'h10; cyc(); mask_wr = 0;
    irq = 8'h10; cyc();
    chk("R2 masked none", int'(none_o), 1);
    chk("R2 masked no int", int'(int_o), 0);
    pulse_ack();
    chk("R7 vec unchanged", int'(vec_o), 0);
    mask_wr = 1; mask = 8'h00; cyc(); mask_wr = 0;
    chk("R7 request kept", int'(int_o), 1);
    pulse_ack();
    chk("R7 later ack", int'(vec_o), 4);

    // random phase checked against model every cycle
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      if (i % 256 == 0) begin
        logic [2:0] md;
        md = 3'($urandom);
        sfnm = md[0]; aeoi = md[1]; rot = md[2];
      end
      irq     = irq ^ 8'($urandom & $urandom & $urandom);
      mask_wr = ($urandom % 16) == 0;
      mask    = 8'($urandom & $urandom);
      base_wr = ($urandom % 32) == 0;
      base    = 3'($urandom);
      ack     = ($urandom % 3) == 0;
      cyc();
      if (i % 997 == 996) do_reset();
    end
    ack = 0;
    finish_run();
  end
endmodule